// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Controller

This block gathers interrupt events from 24 peripheral sources and turns them into interrupt requests for a processor core. Each source owns one bit in each of three register sets: a flag that records the event, an enable that lets the flag through, and a priority bit that picks the request line the source drives. The registers are grouped into three banks of eight bits. A software port reads and writes all registers. Flag registers are cleared by writing 1 to a bit.

A control register holds a global enable, a peripheral enable and a mode bit. With the mode bit at 0 the controller runs in single-level mode. There the peripheral enable acts as a second gate and all sources share the high request line. With the mode bit at 1 the controller runs in two-level mode. There each pending source goes to the high or the low request line according to its priority bit. The global enable gates both lines, and the peripheral enable acts as the extra gate of the low line. A vector-select output tells the core which vector to take; the high request wins when both lines are active.

Top module: `pirq_ctrl`

## Requirements
- R1: After synchronous reset every flag, enable, priority and control bit is 0, and irq_hi, irq_lo and vec_sel are 0.
- R2: A one-cycle pulse on src_evt[n] sets bit n%8 of flag bank n/8 at that clock edge, whatever the enable, priority and control bits are; it reads back from the next cycle.
- R3: A write to flag bank b (address b, b = 0..2) clears each flag bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged.
- R4: When a source pulse and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R5: The hardware never clears a flag; a flag stays set while its request is asserted until software clears it.
- R6: Enable bank b is at address 4+b, priority bank b at address 8+b, and the control register at address 12 holds the global enable in bit 0, the peripheral enable in bit 1 and the mode bit in bit 2; each reads back the last value written, and the unused control bits read 0.
- R7: With the mode bit at 0, irq_hi is 1 exactly when the global enable, the peripheral enable and at least one flag-and-enable pair are all 1; irq_lo is 0 and the priority bits have no effect.
- R8: With the mode bit at 1, irq_hi is 1 exactly when the global enable is 1 and some source has its flag, enable and priority bits all at 1.
- R9: With the mode bit at 1, irq_lo is 1 exactly when the global enable and the peripheral enable are 1 and some source has flag and enable at 1 and priority at 0.
- R10: vec_sel is 1 whenever irq_hi is 1, including when irq_lo is also 1, and 0 otherwise.
- R11: Addresses 3, 7, 11, 13, 14 and 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | 24 | One-cycle event pulses, one per source |
| sw_wr | input | 1 | Software write strobe |
| sw_addr | input | 4 | Register address for reads and writes |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Read data of the addressed register |
| irq_hi | output | 1 | High-priority request to the core |
| irq_lo | output | 1 | Low-priority request to the core |
| vec_sel | output | 1 | 1 selects the high vector, 0 the low vector |

## Verification
Flag, enable, priority and control registers all change at the clock edge that samples a pulse or a write. The request lines and vec_sel are decoded without a register from those values, so they are correct one edge after the stimulus. Read data comes from the address without a register in the same cycle. The bench drives each stimulus for one edge, waits for the falling edge after it and samples there. It drives read addresses on a falling edge and samples one time step later.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int unsigned BANK_W = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned MAX_BANKS = 4;

    typedef enum logic [1:0] {
        GRP_FLAG = 2'd0,
        GRP_EN   = 2'd1,
        GRP_PRI  = 2'd2,
        GRP_CTL  = 2'd3
    } reg_grp_e;

    // bit 2 mode, bit 1 peripheral enable, bit 0 global enable
    typedef struct packed {
        logic prio_mode;
        logic per_en;
        logic glb_en;
    } ctl_t;

    typedef struct packed {
        logic hi;
        logic lo;
        logic vec;
    } irq_t;

    function automatic reg_grp_e addr_grp(input logic [ADDR_W-1:0] a);
        return reg_grp_e'(a[3:2]);
    endfunction

    function automatic logic [1:0] addr_bank(input logic [ADDR_W-1:0] a);
        return a[1:0];
    endfunction

    function automatic logic ctl_hit(input logic [ADDR_W-1:0] a);
        return (addr_grp(a) == GRP_CTL) && (addr_bank(a) == 2'd0);
    endfunction

endpackage

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_evt,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags
);

    logic [W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // set after clear: an event in the clearing cycle survives
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_eff) | set_evt;
        end
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt)));

    p_no_hw_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr_we) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    localparam int unsigned NSRC = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BANK_W-1:0] wr_data,
    output logic [NSRC-1:0]   en_vec,
    output logic [NSRC-1:0]   pri_vec,
    output ctl_t              ctl
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_en, hit_pri;

        always_comb begin
            hit_en  = wr_en && (addr_grp(wr_addr) == GRP_EN)  && (addr_bank(wr_addr) == 2'(b));
            hit_pri = wr_en && (addr_grp(wr_addr) == GRP_PRI) && (addr_bank(wr_addr) == 2'(b));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_vec[b*BANK_W +: BANK_W]  <= '0;
                pri_vec[b*BANK_W +: BANK_W] <= '0;
            end else begin
                if (hit_en)  en_vec[b*BANK_W +: BANK_W]  <= wr_data;
                if (hit_pri) pri_vec[b*BANK_W +: BANK_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr_en && ctl_hit(wr_addr)) begin
            ctl <= ctl_t'(wr_data[2:0]);
        end
    end

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> $stable({en_vec, pri_vec, ctl}));

    p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr_grp(wr_addr) == GRP_CTL) && (addr_bank(wr_addr) != 2'd0))
        |=> $stable(ctl));

endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter
    import pirq_pkg::*;
#(
    parameter int unsigned NSRC = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] en_vec,
    input  logic [NSRC-1:0] pri_vec,
    input  ctl_t            ctl,
    output irq_t            irq
);

    logic [NSRC-1:0] pend;
    logic            any_pend, any_hi, any_lo;

    always_comb begin
        pend     = flags & en_vec;
        any_pend = |pend;
        any_hi   = |(pend & pri_vec);
        any_lo   = |(pend & ~pri_vec);
    end

    always_comb begin
        irq = '0;
        if (ctl.prio_mode) begin
            irq.hi = ctl.glb_en && any_hi;
            irq.lo = ctl.glb_en && ctl.per_en && any_lo;
        end else begin
            irq.hi = ctl.glb_en && ctl.per_en && any_pend;
            irq.lo = 1'b0;
        end
        irq.vec = irq.hi;
    end

    p_lo_off_single_r7: assert property (@(posedge clk) disable iff (rst)
        (!ctl.prio_mode) |-> (!irq.lo));

    p_hi_needs_global_r8: assert property (@(posedge clk) disable iff (rst)
        irq.hi |-> (ctl.glb_en && (|flags)));

    p_lo_needs_gates_r9: assert property (@(posedge clk) disable iff (rst)
        irq.lo |-> (ctl.glb_en && ctl.per_en && ctl.prio_mode && (|(flags & en_vec))));

    p_no_req_no_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> (!irq.hi && !irq.lo));

endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 3,
    localparam int unsigned NSRC = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_evt,
    input  logic              sw_wr,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [BANK_W-1:0] sw_wdata,
    output logic [BANK_W-1:0] sw_rdata,
    output logic              irq_hi,
    output logic              irq_lo,
    output logic              vec_sel
);

    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] en_vec;
    logic [NSRC-1:0] pri_vec;
    ctl_t            ctl;
    irq_t            irq;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flag
        logic clr_we;

        always_comb begin
            clr_we = sw_wr && (addr_grp(sw_addr) == GRP_FLAG) && (addr_bank(sw_addr) == 2'(b));
        end

        pirq_flag_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_evt  (src_evt[b*BANK_W +: BANK_W]),
            .clr_we   (clr_we),
            .clr_mask (sw_wdata),
            .flags    (flags[b*BANK_W +: BANK_W])
        );
    end

    pirq_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sw_wr),
        .wr_addr (sw_addr),
        .wr_data (sw_wdata),
        .en_vec  (en_vec),
        .pri_vec (pri_vec),
        .ctl     (ctl)
    );

    pirq_arbiter #(.NSRC(NSRC)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .en_vec  (en_vec),
        .pri_vec (pri_vec),
        .ctl     (ctl),
        .irq     (irq)
    );

    always_comb begin
        sw_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_bank(sw_addr) == 2'(b)) begin
                case (addr_grp(sw_addr))
                    GRP_FLAG: sw_rdata = flags[b*BANK_W +: BANK_W];
                    GRP_EN:   sw_rdata = en_vec[b*BANK_W +: BANK_W];
                    GRP_PRI:  sw_rdata = pri_vec[b*BANK_W +: BANK_W];
                    default:  sw_rdata = '0;
                endcase
            end
        end
        if (ctl_hit(sw_addr)) begin
            sw_rdata = {{(BANK_W-3){1'b0}}, ctl};
        end
    end

    always_comb begin
        irq_hi  = irq.hi;
        irq_lo  = irq.lo;
        vec_sel = irq.vec;
    end

    p_vec_high_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_hi && irq_lo) |-> vec_sel);

    p_vec_low_r10: assert property (@(posedge clk) disable iff (rst)
        (!irq_hi) |-> (!vec_sel));

endmodule

// File: tb/pirq_ctrl_bench.sv
module pirq_ctrl_bench;

    localparam int NB   = 3;
    localparam int NSRC = NB * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_evt = '0;
    logic            sw_wr = 1'b0;
    logic [3:0]      sw_addr = '0;
    logic [7:0]      sw_wdata = '0;
    logic [7:0]      sw_rdata;
    logic            irq_hi, irq_lo, vec_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model, kept from the requirements
    logic [NSRC-1:0] mflag = '0;
    logic [NSRC-1:0] men   = '0;
    logic [NSRC-1:0] mpri  = '0;
    logic [2:0]      mctl  = '0;

    always #5 clk = ~clk;

    pirq_ctrl #(.NUM_BANKS(NB)) u_pirq_ctrl (
        .clk      (clk),
        .rst      (rst),
        .src_evt  (src_evt),
        .sw_wr    (sw_wr),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata),
        .irq_hi   (irq_hi),
        .irq_lo   (irq_lo),
        .vec_sel  (vec_sel)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d, input logic [NSRC-1:0] evt);
        int b = int'(a[1:0]);
        logic [NSRC-1:0] clr = '0;
        if (a[3:2] == 2'd0 && b < NB) clr[b*8 +: 8] = d;
        if (a[3:2] == 2'd1 && b < NB) men[b*8 +: 8] = d;
        if (a[3:2] == 2'd2 && b < NB) mpri[b*8 +: 8] = d;
        if (a == 4'd12) mctl = d[2:0];
        mflag = (mflag & ~clr) | evt;
    endtask

    task automatic op(input logic wr, input logic [3:0] a, input logic [7:0] d, input logic [NSRC-1:0] evt);
        @(negedge clk);
        sw_wr = wr; sw_addr = a; sw_wdata = d; src_evt = evt;
        @(negedge clk);
        sw_wr = 1'b0; src_evt = '0;
        if (wr) model_write(a, d, evt);
        else    model_write(4'd3, 8'h00, evt);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        op(1'b1, a, d, '0);
    endtask

    task automatic pulse(input logic [NSRC-1:0] evt);
        op(1'b0, 4'd0, 8'h00, evt);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        sw_addr = a;
        #1;
        chk(32'(sw_rdata), 32'(exp), tag);
    endtask

    function automatic logic [7:0] model_rd(input logic [3:0] a);
        int b = int'(a[1:0]);
        if (a == 4'd12) return {5'd0, mctl};
        if (b >= NB) return 8'h00;
        case (a[3:2])
            2'd0:    return mflag[b*8 +: 8];
            2'd1:    return men[b*8 +: 8];
            2'd2:    return mpri[b*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic irq_chk(input string tag);
        logic [NSRC-1:0] p = mflag & men;
        logic eh, el;
        if (mctl[2]) begin
            eh = mctl[0] & (|(p & mpri));
            el = mctl[0] & mctl[1] & (|(p & ~mpri));
        end else begin
            eh = mctl[0] & mctl[1] & (|p);
            el = 1'b0;
        end
        chk(32'(irq_hi), 32'(eh), {tag, " irq_hi"});
        chk(32'(irq_lo), 32'(el), {tag, " irq_lo"});
        chk(32'(vec_sel), 32'(eh), {tag, " vec_sel R10"});
    endtask

    task automatic clear_all();
        for (int b = 0; b < NB; b++) wr(4'(b), 8'hFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, R11: unmapped reads
        for (int a = 0; a < 16; a++) rd_chk(4'(a), 8'h00, "R1 reset value");
        chk(32'({irq_hi, irq_lo, vec_sel}), 32'd0, "R1 outputs after reset");

        // R2: flag sets with every enable at 0
        pulse(24'h000020);
        rd_chk(4'd0, 8'h20, "R2 flag set while disabled");
        irq_chk("R2");
        pulse(24'h810000);
        rd_chk(4'd2, 8'h81, "R2 bank2 flags");

        // R6: readback of enable, priority, control
        wr(4'd4, 8'h3C); wr(4'd5, 8'hC3); wr(4'd6, 8'h5A);
        wr(4'd8, 8'h0F); wr(4'd9, 8'hF0); wr(4'd10, 8'h99);
        wr(4'd12, 8'hF8);
        for (int a = 4; a < 13; a++) rd_chk(4'(a), model_rd(4'(a)), "R6 readback");
        wr(4'd12, 8'hFF);
        rd_chk(4'd12, 8'h07, "R6 control unused bits");

        // R11: writes to unmapped addresses change nothing
        wr(4'd3, 8'hFF); wr(4'd7, 8'hFF); wr(4'd11, 8'hFF);
        wr(4'd13, 8'h00); wr(4'd14, 8'h00); wr(4'd15, 8'h00);
        for (int a = 0; a < 16; a++) rd_chk(4'(a), model_rd(4'(a)), "R11 unmapped write");

        // R3: write-1-to-clear
        wr(4'd12, 8'h00);
        pulse(24'h00FF00);
        rd_chk(4'd1, 8'hFF, "R3 setup");
        wr(4'd1, 8'hA5);
        rd_chk(4'd1, 8'h5A, "R3 partial clear");

        // R4: set beats clear
        op(1'b1, 4'd1, 8'hFF, 24'h000200);
        rd_chk(4'd1, 8'h02, "R4 set wins over clear");

        // R5: flag held while request asserted
        clear_all();
        wr(4'd4, 8'h01); wr(4'd12, 8'h03);
        pulse(24'h000001);
        irq_chk("R7 single-level request");
        repeat (10) @(negedge clk);
        rd_chk(4'd0, 8'h01, "R5 flag not cleared by hardware");
        chk(32'(irq_hi), 32'd1, "R5 request held");

        // R7/R8/R9: single source sweep over control, priority, enable
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < NSRC; s++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [NSRC-1:0] ev = '0;
                    logic [NSRC-1:0] en = '0;
                    logic [NSRC-1:0] pr = '0;
                    ev[s] = 1'b1;
                    en[s] = k[0];
                    pr[s] = k[1];
                    clear_all();
                    for (int b = 0; b < NB; b++) begin
                        wr(4'(4 + b), en[b*8 +: 8]);
                        wr(4'(8 + b), pr[b*8 +: 8]);
                    end
                    wr(4'd12, 8'(c));
                    irq_chk("R2 no flag no request");
                    pulse(ev);
                    irq_chk(c[2] ? "R8 R9 two-level single source" : "R7 single-level source");
                end
            end
        end

        // R9/R10: two sources at different levels at once
        for (int b = 0; b < NB; b++) begin
            wr(4'(4 + b), 8'hFF);
        end
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < NSRC; s++) begin
                int t = (s + 7) % NSRC;
                logic [NSRC-1:0] pr = '0;
                logic [NSRC-1:0] ev = '0;
                pr[s] = 1'b1;
                ev[s] = 1'b1;
                ev[t] = 1'b1;
                clear_all();
                for (int b = 0; b < NB; b++) wr(4'(8 + b), pr[b*8 +: 8]);
                wr(4'd12, 8'(c));
                pulse(ev);
                irq_chk("R9 R10 both levels");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule